// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM With Posted Writes

This block is a single-port synchronous SRAM for use inside a larger chip. Address and control are sampled on the rising clock edge. Reads and writes may follow each other in any order on consecutive cycles, and no idle cycles are needed between them. Read data flows straight from the storage array to the data output during the cycle that follows the sampling edge. No output register sits in that path. Write data arrives one cycle after its address and waits in a single-entry write register, which updates the array one enabled cycle later. While a write waits there, a read of the same word returns the waiting data, merged lane by lane with the array contents.

The word has two 9-bit lanes, and each lane has its own write select. A word may be selected only when all three chip selects are active. A load/advance input either starts an access at a new external address or steps a 2-bit burst counter. The burst runs in counting order or in XOR order. A clock enable freezes every register. The data bus is split into an input, an output and a drive enable, which go to a bidirectional pad. The drive enable stays low during every write data cycle, whatever the output enable does.

Top module: `fts_sram`

## Requirements
- R1: While reset is held, and after it is released, no access is active and `dq_oe` is low until a read is sampled.
- R2: A read sampled at an enabled edge drives the addressed word on `dq_o`, with `dq_oe` high, during the cycle that follows that edge. Reads and writes may alternate on consecutive cycles with no idle cycle.
- R3: For a write sampled at edge k, the data is taken from `dq_i` at the next enabled edge. The array is updated at the enabled edge after that.
- R4: A read of a word whose write is still waiting in the write register returns the waiting lanes, and the array contents for the other lanes.
- R5: `lane_we[0]` enables bits 8:0 and `lane_we[1]` enables bits 17:9. A lane whose select is low keeps its old value.
- R6: A load selects the word only when `cs0`=1, `cs1_n`=0 and `cs2`=1. Any other pattern gives a deselect cycle: nothing is written, `dq_oe` stays low, and advances that follow stay deselected.
- R7: While `clk_en` is low, no register changes, so no access starts, no write is taken or committed, and `dq_o`/`dq_oe` hold.
- R8: With `burst_ilv`=0 at the load, the low two address bits count up modulo 4 from the loaded value on each advance.
- R9: With `burst_ilv`=1 at the load, the low two address bits are the loaded value XOR the beat count (0..3). The order is fixed at the load.
- R10: An advance (`ld_new`=0) repeats the kind of access set by the last load. During an advance, `wr_en`, the chip selects and `addr` are ignored, and `lane_we` is sampled again for each beat.
- R11: `dq_oe` is high only during a read cycle while `out_en` is high. It follows `out_en` within the cycle, without a clock edge, and it is never high during a write data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| clk_en | input | 1 | Clock qualifier; low freezes the block |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| ld_new | input | 1 | 1 loads `addr`, 0 advances the burst |
| wr_en | input | 1 | 1 = write, 0 = read, at a load |
| lane_we | input | 2 | Per-lane write selects |
| burst_ilv | input | 1 | Burst order at a load: 0 counting, 1 XOR |
| addr | input | 8 | Word address |
| out_en | input | 1 | Output enable, combinational |
| dq_i | input | 18 | Write data from the pad |
| dq_o | output | 18 | Read data to the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
Two functions can fall in the same cycle. A read can be sampled while the write register still holds a word for the same address, so the merge and the array path compete for that read. The bench provokes this with a write followed at once by a read of the same address, using full-lane and partial-lane writes, and with bursts that read back words written in the beats just before. The bench judges each case against a reference memory that it updates when each write's data is given. The clock-enable freeze is also laid over a pending write, to show that capture and forwarding wait for the next enabled edge.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } fts_op_e;

  // Low two address bits for beat 'cnt' of a burst that started at 'base'.
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = base ^ cnt;
    else     r = base + cnt;
    return r;
  endfunction

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sel_all,
  input  logic             ld_new,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_we,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  output fts_op_e          cur_op,
  output logic [AW-1:0]    cur_addr,
  output logic [LANES-1:0] cur_lanes
);

  fts_op_e          op_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             ilv_q;
  logic [LANES-1:0] lanes_q;

  // named events for the checks
  logic adv_evt;
  logic load_evt;
  assign adv_evt  = clk_en && !ld_new;
  assign load_evt = clk_en && ld_new;

  fts_op_e load_op;
  always_comb begin
    if (!sel_all)   load_op = OP_IDLE;
    else if (wr_en) load_op = OP_WR;
    else            load_op = OP_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      ilv_q   <= 1'b0;
      lanes_q <= '0;
    end else if (load_evt) begin
      op_q    <= load_op;
      base_q  <= addr;
      cnt_q   <= '0;
      ilv_q   <= burst_ilv;
      lanes_q <= lane_we;
    end else if (adv_evt) begin
      cnt_q   <= cnt_q + 2'd1;
      lanes_q <= lane_we;
    end
  end

  assign cur_op    = op_q;
  assign cur_lanes = lanes_q;
  assign cur_addr  = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_q, ilv_q)};

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(op_q) && $stable(cur_addr) && $stable(lanes_q));

  // R8
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && !ilv_q |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

  // R10
  adv_keep_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> op_q == $past(op_q) && cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]));

  // R9
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && ilv_q |=> $countones(cur_addr[1:0] ^ $past(cur_addr[1:0])) >= 1);

endmodule

// File: rtl/fts_wbuf.sv
module fts_wbuf #(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2,
  localparam int W    = LW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             cap,
  input  logic [AW-1:0]    cap_addr,
  input  logic [LANES-1:0] cap_lanes,
  input  logic [W-1:0]     din,
  input  logic [AW-1:0]    rd_addr,
  input  logic [W-1:0]     arr_rdata,
  output logic             commit_en,
  output logic [AW-1:0]    commit_addr,
  output logic [LANES-1:0] commit_lanes,
  output logic [W-1:0]     commit_data,
  output logic [W-1:0]     rd_merged,
  output logic             fwd_hit
);

  logic             pend_v;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_lanes;
  logic [W-1:0]     pend_data;

  // Lane-wise merge: lanes with sel set come from nw, others from old.
  function automatic logic [W-1:0] lane_merge(input logic [W-1:0]     old,
                                              input logic [W-1:0]     nw,
                                              input logic [LANES-1:0] sel);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < LANES; i++)
      if (sel[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      pend_lanes <= '0;
      pend_data  <= '0;
    end else if (clk_en) begin
      pend_v <= cap;
      if (cap) begin
        pend_addr  <= cap_addr;
        pend_lanes <= cap_lanes;
        pend_data  <= din;
      end
    end
  end

  assign commit_en    = clk_en && pend_v;
  assign commit_addr  = pend_addr;
  assign commit_lanes = pend_lanes;
  assign commit_data  = pend_data;

  assign fwd_hit   = pend_v && (pend_addr == rd_addr);
  assign rd_merged = lane_merge(arr_rdata, pend_data, fwd_hit ? pend_lanes : '0);

  // R3
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && cap |=> pend_v && pend_data == $past(din));

  // R3
  wr_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !cap |=> !pend_v);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(pend_v) && $stable(pend_data));

endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2,
  localparam int W     = LW * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wlanes,
  input  logic [W-1:0]     wdata,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlanes[g]) mem[waddr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = mem[raddr];
  end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LW    = 9,
  parameter int LANES = 2,
  localparam int W    = LW * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             cs0,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             ld_new,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_we,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic             out_en,
  input  logic [W-1:0]     dq_i,
  output logic [W-1:0]     dq_o,
  output logic             dq_oe
);

  logic             sel_all;
  fts_op_e          cur_op;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] cur_lanes;

  logic             wr_data_cyc;
  logic             rd_cyc;

  logic             commit_en;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_lanes;
  logic [W-1:0]     commit_data;
  logic [W-1:0]     arr_rdata;
  logic [W-1:0]     rd_merged;
  logic             fwd_hit;

  assign sel_all = cs0 && !cs1_n && cs2;

  fts_ctrl #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sel_all   (sel_all),
    .ld_new    (ld_new),
    .wr_en     (wr_en),
    .lane_we   (lane_we),
    .burst_ilv (burst_ilv),
    .addr      (addr),
    .cur_op    (cur_op),
    .cur_addr  (cur_addr),
    .cur_lanes (cur_lanes)
  );

  assign wr_data_cyc = (cur_op == OP_WR);
  assign rd_cyc      = (cur_op == OP_RD);

  fts_wbuf #(.AW(AW), .LW(LW), .LANES(LANES)) wbuf_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en       (clk_en),
    .cap          (wr_data_cyc),
    .cap_addr     (cur_addr),
    .cap_lanes    (cur_lanes),
    .din          (dq_i),
    .rd_addr      (cur_addr),
    .arr_rdata    (arr_rdata),
    .commit_en    (commit_en),
    .commit_addr  (commit_addr),
    .commit_lanes (commit_lanes),
    .commit_data  (commit_data),
    .rd_merged    (rd_merged),
    .fwd_hit      (fwd_hit)
  );

  fts_array #(.AW(AW), .LW(LW), .LANES(LANES)) array_i (
    .clk    (clk),
    .we     (commit_en),
    .waddr  (commit_addr),
    .wlanes (commit_lanes),
    .wdata  (commit_data),
    .raddr  (cur_addr),
    .rdata  (arr_rdata)
  );

  assign dq_o  = rd_merged;
  assign dq_oe = rd_cyc && out_en;

  // R11
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_cyc |-> !dq_oe);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !dq_oe);

  // R4
  fwd_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit && dq_oe |-> rd_cyc);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !dq_oe);

endmodule

// File: tb/fts_sram_tb.sv
module fts_sram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] ON  = 3'b101;  // {cs0, cs1_n, cs2}
  localparam logic [2:0] OFF = 3'b000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en;
  logic        cs0, cs1_n, cs2;
  logic        ld_new, wr_en, burst_ilv, out_en;
  logic [1:0]  lane_we;
  logic [7:0]  addr;
  logic [17:0] dq_i, dq_o;
  logic        dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [17:0] ref_m [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  fts_sram dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .cs0(cs0), .cs1_n(cs1_n), .cs2(cs2),
    .ld_new(ld_new), .wr_en(wr_en), .lane_we(lane_we),
    .burst_ilv(burst_ilv), .addr(addr), .out_en(out_en),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_ok(input string req, input logic [17:0] exp);
    chk({req, " drive"}, {17'b0, dq_oe}, 18'd1);
    chk({req, " data"}, dq_o, exp);
  endtask

  task automatic off(input string req);
    chk({req, " no drive"}, {17'b0, dq_oe}, 18'd0);
  endtask

  // Bench-side reference write: lane 0 = bits 8:0, lane 1 = bits 17:9.
  task automatic wref(input logic [7:0] a, input logic [1:0] ln, input logic [17:0] d);
    if (ln[0]) ref_m[a][8:0]  = d[8:0];
    if (ln[1]) ref_m[a][17:9] = d[17:9];
  endtask

  // Sets controls for the next edge and dq_i for the current cycle,
  // then waits to mid-cycle where outputs of the last edge are judged.
  task automatic go(input logic ce, input logic l, input logic w, input logic [2:0] cs,
                    input logic [7:0] a, input logic [1:0] ln, input logic il,
                    input logic [17:0] d);
    @(posedge clk); #1;
    clk_en = ce; ld_new = l; wr_en = w; {cs0, cs1_n, cs2} = cs;
    addr = a; lane_we = ln; burst_ilv = il; dq_i = d;
    @(negedge clk);
  endtask

  task automatic idle(input logic [17:0] d);
    go(1, 1, 0, OFF, 8'h00, 2'b00, 0, d);
  endtask

  task automatic t_reset;
    off("R1 after reset");
    idle(0);
    off("R1 first idle cycle");
  endtask

  task automatic t_rw_mix;
    go(1, 1, 1, ON, 8'd10, 2'b11, 0, 0);
    go(1, 1, 1, ON, 8'd11, 2'b11, 0, 18'h2A5A5);
    wref(10, 2'b11, 18'h2A5A5);
    off("R11 write data cycle");
    go(1, 1, 0, ON, 8'd10, 2'b00, 0, 18'h15A5A);
    wref(11, 2'b11, 18'h15A5A);
    off("R11 second write data cycle");
    go(1, 1, 0, ON, 8'd11, 2'b00, 0, 0);
    rd_ok("R2 read after two writes", ref_m[10]);
    go(1, 1, 1, ON, 8'd10, 2'b11, 0, 0);
    rd_ok("R3 back-to-back read", ref_m[11]);
    go(1, 1, 0, ON, 8'd10, 2'b00, 0, 18'h3C00F);
    wref(10, 2'b11, 18'h3C00F);
    off("R3 write between reads");
    idle(0);
    rd_ok("R4 read of pending word", ref_m[10]);
  endtask

  task automatic t_lanes;
    go(1, 1, 1, ON, 8'd20, 2'b11, 0, 0);
    go(1, 1, 1, ON, 8'd20, 2'b10, 0, 18'h00155);
    wref(20, 2'b11, 18'h00155);
    go(1, 1, 0, ON, 8'd20, 2'b00, 0, 18'h3FE00);
    wref(20, 2'b10, 18'h3FE00);
    idle(0);
    rd_ok("R5 upper lane merged over array", ref_m[20]);
    go(1, 1, 1, ON, 8'd20, 2'b01, 0, 0);
    go(1, 1, 0, ON, 8'd20, 2'b00, 0, 18'h000AA);
    wref(20, 2'b01, 18'h000AA);
    idle(0);
    rd_ok("R4 lower lane forwarded", ref_m[20]);
    idle(0);
  endtask

  task automatic t_desel;
    logic [2:0] pats [3] = '{3'b001, 3'b111, 3'b100};
    for (int p = 0; p < 3; p++) begin
      go(1, 1, 1, pats[p], 8'd10, 2'b11, 0, 0);
      go(1, 1, 0, ON, 8'd10, 2'b00, 0, 18'h0DEAD);
      off("R6 deselect cycle");
      idle(0);
      rd_ok("R6 deselected write ignored", ref_m[10]);
      go(1, 1, 0, pats[p], 8'd11, 2'b00, 0, 0);
      go(1, 0, 0, ON, 8'd11, 2'b00, 0, 0);
      off("R6 deselected read");
      idle(0);
      off("R6 advance after deselect");
    end
  endtask

  task automatic t_freeze;
    go(1, 1, 0, ON, 8'd10, 2'b00, 0, 0);
    go(0, 1, 1, ON, 8'd11, 2'b11, 0, 18'h11111);
    rd_ok("R2 read before freeze", ref_m[10]);
    go(0, 1, 1, ON, 8'd11, 2'b11, 0, 18'h22222);
    rd_ok("R7 frozen cycle one", ref_m[10]);
    go(1, 1, 0, ON, 8'd11, 2'b00, 0, 0);
    rd_ok("R7 frozen cycle two", ref_m[10]);
    idle(0);
    rd_ok("R7 frozen write not taken", ref_m[11]);
    go(1, 1, 1, ON, 8'd12, 2'b11, 0, 0);
    go(0, 1, 0, OFF, 8'd0, 2'b00, 0, 18'h24680);
    go(0, 1, 0, OFF, 8'd0, 2'b00, 0, 18'h24680);
    off("R7 write data held through freeze");
    go(1, 1, 0, ON, 8'd12, 2'b00, 0, 18'h24680);
    wref(12, 2'b11, 18'h24680);
    idle(0);
    rd_ok("R7 write taken after freeze", ref_m[12]);
  endtask

  // Burst write then read; order counted by the bench itself.
  task automatic t_burst(input logic il, input logic [7:0] wbase, input logic [7:0] rbase,
                         input string req);
    logic [7:0] a;
    logic [17:0] d;
    go(1, 1, 1, ON, wbase, 2'b11, il, 0);
    for (int b = 0; b < 4; b++) begin
      a = {wbase[7:2], il ? (wbase[1:0] ^ 2'(b)) : (wbase[1:0] + 2'(b))};
      d = 18'h10000 + 18'(a) * 18'h00111;
      if (b < 3) go(1, 0, 0, OFF, 8'hFF, 2'b11, 0, d);  // R10: wr_en/cs/addr ignored
      else       idle(d);
      wref(a, 2'b11, d);
    end
    go(1, 1, 0, ON, rbase, 2'b00, il, 0);
    for (int b = 0; b < 4; b++) begin
      a = {rbase[7:2], il ? (rbase[1:0] ^ 2'(b)) : (rbase[1:0] + 2'(b))};
      if (b < 3) go(1, 0, 1, OFF, 8'h00, 2'b11, ~il, 0);  // R10: advance keeps read
      else       idle(0);
      rd_ok(req, ref_m[a]);
    end
  endtask

  task automatic t_oe;
    go(1, 1, 0, ON, 8'd11, 2'b00, 0, 0);
    idle(0);
    rd_ok("R11 read with output enable", ref_m[11]);
    #1 out_en = 1'b0; #1;
    off("R11 output enable dropped mid-cycle");
    out_en = 1'b1; #1;
    rd_ok("R11 output enable restored mid-cycle", ref_m[11]);
  endtask

  initial begin
    rst_n = 0; clk_en = 1; {cs0, cs1_n, cs2} = OFF; ld_new = 1; wr_en = 0;
    lane_we = 0; burst_ilv = 0; addr = 0; out_en = 1; dq_i = 0;
    for (int i = 0; i < 256; i++) ref_m[i] = 18'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    off("R1 during reset");
    rst_n = 1;
    // give every touched word a known value first
    for (int i = 0; i < 64; i++) begin
      go(1, 1, 1, ON, 8'(i), 2'b11, 0, (i == 0) ? 18'h0 : 18'(i - 1));
    end
    idle(18'd63);
    idle(0);
    for (int i = 0; i < 64; i++) ref_m[i] = 18'(i);
    t_reset();
    t_rw_mix();
    t_lanes();
    t_desel();
    t_freeze();
    t_burst(0, 8'd42, 8'd41, "R8 counting burst");
    t_burst(1, 8'd45, 8'd46, "R9 xor burst");
    t_oe();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule